// File: doc/BRIEF.md
# Three-Wire Serial Master Controller

This block is a master for a three-wire synchronous serial link: serial clock out, data out, data in. It also drives a set of chip-select lines. Software reaches it through a small 16-bit register bus with byte offsets. The bus provides a data register, a command/status register, two registers that each hold the setup for a pair of selects, and a clock setup register.

A single command names a select and gives two bit counts, one for transmit and one for receive. The transmit bits are shifted out first, MSB first, from the left-justified data register. The receive bits are then shifted in and land right-justified in the same register. Each select has its own settings:

- the serial clock edge on which outgoing data changes;
- the edge on which incoming data is sampled;
- the active level of its select line;
- a serial clock divider, applied after a shared base prescaler.

Chip-select lines are asserted and released by separate commands.

Top module: `mw_master`

## Requirements
- R1: After reset, every register reads zero, `sclk` and `sdo` are low and every `cs_out` bit sits at its inactive level, which is 1 because the active level resets to 0.
- R2: Registers sit at these byte offsets: data 0x0, command/status 0x2, select setup for selects 0/1 at 0x4, select setup for selects 2/3 at 0x6, clock setup 0x8. A select setup register holds select 2k in bits [5:0] and select 2k+1 in bits [11:6], and reads zero above bit 11. The clock setup register keeps bits [2:0] and reads zero above them.
- R3: Command/status bit fields are:
  - [4:0] receive count;
  - [9:5] transmit count;
  - [11:10] select index;
  - 12 select-assert flag;
  - 13 start;
  - 14 busy (read);
  - 15 receive-ready (read).

  Writing with start=0 asserts the indexed select when bit 12 is 1, or releases every select when bit 12 is 0. Busy reads 1 in the cycle after such a write and 0 in the cycle after that.
- R4: In a 6-bit select setup field, bit 2 is the active level. An asserted select drives that level, and every other select drives the inverse of its own level. At most one select is active at a time.
- R5: Transmit bits leave MSB first, starting at data bit 15. With setup bit 1 = 0, each bit changes on a rising serial clock edge, and `sdo` is low before the first rise. With bit 1 = 1, bit 15 is present from the start and each later bit changes on a falling edge.
- R6: Received bits are captured on the rising edge when setup bit 0 = 0, and on the falling edge when it is 1. The first bit received becomes the MSB of the right-justified result, and unused upper bits are zero. Busy stays 1 until the result is in the data register, and receive-ready rises as busy drops.
- R7: In a combined command the transmit phase runs before the receive phase. A zero receive count gives a transmit-only command, which leaves the data register unchanged and receive-ready low. A zero transmit count gives a receive-only command.
- R8: A start with both counts zero starts nothing, and busy stays 0. A count field above 16 acts as 16.
- R9: A bus read of the data register clears receive-ready. A new start also clears it.
- R10: While busy is 1, writes to the command/status and data registers are ignored. This covers starts and select commands.
- R11: One serial clock period lasts B×S system clocks. B is 2, 4, 7 or 10 for clock setup bits [2:1] = 0..3. S is 2, 4 or 8 for select setup bits [4:3] = 0, 1, 2, and code 3 also gives 8.
- R12: The serial clock is low whenever no command runs. While the clock setup enable (bit 0) is 0, the serial clock does not move and a started command waits. It finishes once the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (used for read side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the slave |
| sdi | input | 1 | Serial data from the slave |
| cs_out | output | 4 | Chip-select lines, per-select polarity |

## Verification
Transfers are run with transmit-only, receive-only and combined commands. Counts include 1, 5, 8, 12, 16 and an over-range 20, so that bit ordering, justification and the masking of unused upper bits each show up in a different case. A bench-side slave captures data and drives input on edges chosen from the select setup. Both settings of the launch edge and of the sample edge are exercised, and a design that uses the wrong edge reads back a shifted or wrong word. The serial clock period is measured under four prescaler and divider pairs, including the odd /7 and the largest /10 with /8, to tell the two dividers apart. Select commands run with mixed polarities. Writes issued during a running command must leave the captured bit count, the result and the select lines unchanged.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int DW      = 16;
    localparam int NCS     = 4;
    localparam int CNT_W   = 5;
    localparam int CFG_W   = 6;
    localparam int BASE_CW = 4;
    localparam int HALF_CW = 3;

    localparam logic [3:0] A_DATA  = 4'h0;
    localparam logic [3:0] A_CTRL  = 4'h2;
    localparam logic [3:0] A_SEL01 = 4'h4;
    localparam logic [3:0] A_SEL23 = 4'h6;
    localparam logic [3:0] A_CLK   = 4'h8;

    localparam int F_RD    = 0;
    localparam int F_WR    = 5;
    localparam int F_IDX   = 10;
    localparam int F_ASSERT = 12;
    localparam int F_START = 13;

    typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_e;

    typedef struct packed {
        logic       spare;
        logic [1:0] div;
        logic       level;
        logic       tx_fall;
        logic       rx_fall;
    } sel_cfg_t;

    function automatic logic [BASE_CW-1:0] base_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return BASE_CW'(2);
            2'd1:    return BASE_CW'(4);
            2'd2:    return BASE_CW'(7);
            default: return BASE_CW'(10);
        endcase
    endfunction

    function automatic logic [HALF_CW-1:0] half_ratio(input logic [1:0] code);
        case (code)
            2'd0:    return HALF_CW'(1);
            2'd1:    return HALF_CW'(2);
            default: return HALF_CW'(4);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] n);
        return (n > CNT_W'(DW)) ? CNT_W'(DW) : n;
    endfunction

endpackage

// File: rtl/mw_prescale.sv
module mw_prescale
    import mw_pkg::*;
#(
    parameter int BW = BASE_CW,
    parameter int HW = HALF_CW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [1:0] base_code,
    input  logic [1:0] half_code,
    output logic       half_tick
);
    logic [BW-1:0] bcnt, blim;
    logic [HW-1:0] hcnt, hlim;
    logic          btick;

    assign blim      = BW'(base_ratio(base_code)) - BW'(1);
    assign hlim      = HW'(half_ratio(half_code)) - HW'(1);
    assign btick     = run && (bcnt == blim);
    assign half_tick = btick && (hcnt == hlim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bcnt <= '0;
            hcnt <= '0;
        end else begin
            bcnt <= btick ? '0 : bcnt + BW'(1);
            if (btick)
                hcnt <= half_tick ? '0 : hcnt + HW'(1);
        end
    end
endmodule

// File: rtl/mw_shift.sv
module mw_shift
    import mw_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CW-1:0]     wr_n,
    input  logic [CW-1:0]     rd_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              half_tick,
    input  logic              tx_fall,
    input  logic              rx_fall,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              running,
    output logic              done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_word
);
    phase_e            ph;
    logic [CW-1:0]     bitn, wr_q, rd_q, phase_len;
    logic [DATA_W-1:0] txsh, rxsh;
    logic              sclk_q, sdo_q, done_q, rx_done_q, last_bit;

    assign phase_len = (ph == PH_TX) ? wr_q : rd_q;
    assign last_bit  = (bitn + CW'(1)) == phase_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            bitn      <= '0;
            wr_q      <= '0;
            rd_q      <= '0;
            txsh      <= '0;
            rxsh      <= '0;
            sclk_q    <= 1'b0;
            sdo_q     <= 1'b0;
            done_q    <= 1'b0;
            rx_done_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            rx_done_q <= 1'b0;
            if (ph == PH_IDLE) begin
                if (start) begin
                    ph     <= (wr_n != '0) ? PH_TX : PH_RX;
                    wr_q   <= wr_n;
                    rd_q   <= rd_n;
                    txsh   <= tx_word;
                    rxsh   <= '0;
                    bitn   <= '0;
                    sclk_q <= 1'b0;
                    sdo_q  <= 1'b0;
                end
            end else if (half_tick) begin
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    if (ph == PH_TX && !tx_fall) begin
                        sdo_q <= txsh[DATA_W-1];
                        txsh  <= {txsh[DATA_W-2:0], 1'b0};
                    end
                    if (ph == PH_RX && !rx_fall)
                        rxsh <= {rxsh[DATA_W-2:0], sdi};
                end else begin
                    if (ph == PH_TX && tx_fall)
                        txsh <= {txsh[DATA_W-2:0], 1'b0};
                    if (ph == PH_RX && rx_fall)
                        rxsh <= {rxsh[DATA_W-2:0], sdi};
                    if (last_bit) begin
                        bitn <= '0;
                        if (ph == PH_TX && rd_q != '0) begin
                            ph <= PH_RX;
                        end else begin
                            ph        <= PH_IDLE;
                            done_q    <= 1'b1;
                            rx_done_q <= (ph == PH_RX);
                        end
                    end else begin
                        bitn <= bitn + CW'(1);
                    end
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign sdo     = (ph == PH_TX) ? (tx_fall ? txsh[DATA_W-1] : sdo_q) : 1'b0;
    assign running = (ph != PH_IDLE);
    assign done    = done_q;
    assign rx_done = rx_done_q;
    assign rx_word = rxsh;
endmodule

// File: rtl/mw_csel.sv
module mw_csel
    import mw_pkg::*;
#(
    parameter int N_SEL = NCS,
    localparam int IDX_W = $clog2(N_SEL)
) (
    input  logic             act,
    input  logic [IDX_W-1:0] idx,
    input  logic [N_SEL-1:0] level,
    output logic [N_SEL-1:0] cs_out
);
    for (genvar i = 0; i < N_SEL; i++) begin : g_line
        assign cs_out[i] = (act && idx == IDX_W'(i)) ? level[i] : ~level[i];
    end
endmodule

// File: rtl/mw_master.sv
module mw_master
    import mw_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int N_SEL  = NCS,
    parameter int CW     = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic [N_SEL-1:0]  cs_out
);
    localparam int IDX_W = $clog2(N_SEL);

    sel_cfg_t          sel_cfg [N_SEL];
    logic [N_SEL-1:0]  lvl_vec;
    logic [DATA_W-1:0] data_q, rx_word;
    logic [CW-1:0]     rd_cnt_q, wr_cnt_q, rd_eff, wr_eff;
    logic [IDX_W-1:0]  idx_q, cs_idx_q, wr_idx;
    logic              cs_act_q, cs_busy_q, rdy_q, clk_en_q;
    logic [1:0]        base_code_q, x_div_q;
    logic              x_txf_q, x_rxf_q;
    logic              xfer_busy, done, rx_done, half_tick, busy;
    logic              wr_ctl, start_go;

    assign busy   = xfer_busy || done || cs_busy_q;
    assign wr_ctl = bus_we && (bus_addr == A_CTRL) && !busy;
    assign rd_eff = clamp_cnt(bus_wdata[F_RD +: CW]);
    assign wr_eff = clamp_cnt(bus_wdata[F_WR +: CW]);
    assign wr_idx = bus_wdata[F_IDX +: IDX_W];
    assign start_go = wr_ctl && bus_wdata[F_START] && ((rd_eff | wr_eff) != '0);

    for (genvar i = 0; i < N_SEL; i++) begin : g_sel
        localparam logic [3:0] ADDR = 4'(int'(A_SEL01) + 2 * (i / 2));
        localparam int OFS = (i % 2) * CFG_W;
        sel_cfg_t cfg_q;
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q <= '0;
            else if (bus_we && bus_addr == ADDR)
                cfg_q <= sel_cfg_t'(bus_wdata[OFS +: CFG_W]);
        end
        assign sel_cfg[i] = cfg_q;
        assign lvl_vec[i] = cfg_q.level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q      <= '0;
            rd_cnt_q    <= '0;
            wr_cnt_q    <= '0;
            idx_q       <= '0;
            cs_idx_q    <= '0;
            cs_act_q    <= 1'b0;
            cs_busy_q   <= 1'b0;
            rdy_q       <= 1'b0;
            clk_en_q    <= 1'b0;
            base_code_q <= '0;
            x_div_q     <= '0;
            x_txf_q     <= 1'b0;
            x_rxf_q     <= 1'b0;
        end else begin
            cs_busy_q <= 1'b0;
            if (bus_we && bus_addr == A_CLK)
                {base_code_q, clk_en_q} <= bus_wdata[2:0];
            if (bus_we && bus_addr == A_DATA && !busy)
                data_q <= bus_wdata;
            if (wr_ctl) begin
                rd_cnt_q <= bus_wdata[F_RD +: CW];
                wr_cnt_q <= bus_wdata[F_WR +: CW];
                idx_q    <= wr_idx;
                if (bus_wdata[F_START]) begin
                    if (start_go) begin
                        x_div_q <= sel_cfg[wr_idx].div;
                        x_txf_q <= sel_cfg[wr_idx].tx_fall;
                        x_rxf_q <= sel_cfg[wr_idx].rx_fall;
                    end
                end else begin
                    cs_act_q  <= bus_wdata[F_ASSERT];
                    cs_idx_q  <= wr_idx;
                    cs_busy_q <= 1'b1;
                end
            end
            if (rx_done)
                data_q <= rx_word;
            if (rx_done)
                rdy_q <= 1'b1;
            else if (start_go || (bus_re && bus_addr == A_DATA))
                rdy_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = data_q;
            A_CTRL:  bus_rdata = DATA_W'({rdy_q, busy, 1'b0, cs_act_q, idx_q, wr_cnt_q, rd_cnt_q});
            A_SEL01: bus_rdata = DATA_W'({sel_cfg[1], sel_cfg[0]});
            A_SEL23: bus_rdata = DATA_W'({sel_cfg[3], sel_cfg[2]});
            A_CLK:   bus_rdata = DATA_W'({base_code_q, clk_en_q});
            default: bus_rdata = '0;
        endcase
    end

    mw_prescale u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (clk_en_q && xfer_busy),
        .base_code (base_code_q),
        .half_code (x_div_q),
        .half_tick (half_tick)
    );

    mw_shift #(.DATA_W(DATA_W), .CW(CW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (start_go),
        .wr_n      (wr_eff),
        .rd_n      (rd_eff),
        .tx_word   (data_q),
        .half_tick (half_tick),
        .tx_fall   (x_txf_q),
        .rx_fall   (x_rxf_q),
        .sdi       (sdi),
        .sclk      (sclk),
        .sdo       (sdo),
        .running   (xfer_busy),
        .done      (done),
        .rx_done   (rx_done),
        .rx_word   (rx_word)
    );

    mw_csel #(.N_SEL(N_SEL)) u_csel (
        .act    (cs_act_q),
        .idx    (cs_idx_q),
        .level  (lvl_vec),
        .cs_out (cs_out)
    );
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk
    import mw_pkg::*;
#(
    parameter int N_SEL = NCS
) (
    input logic             clk,
    input logic             rst,
    input logic             sclk,
    input logic             sdo,
    input logic [N_SEL-1:0] cs_out,
    input logic [N_SEL-1:0] lvl_vec,
    input logic             bus_we,
    input logic             bus_re,
    input logic [3:0]       bus_addr,
    input logic             xfer_busy,
    input logic             busy,
    input logic             clk_en,
    input logic             rdy,
    input logic             rx_done
);
    a_r12_sclk_idle: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !sclk);

    a_r12_sclk_frozen: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(sclk));

    a_r5_sdo_quiet: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> !sdo);

    a_r4_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~(cs_out ^ lvl_vec)));

    a_r9_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == A_DATA && !rx_done) |=> !rdy);

    a_r10_busy_blocks_select: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_we && bus_addr == A_CTRL) |=> $stable(cs_out));

    a_r6_ready_at_release: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> !busy);
endmodule

bind mw_master mw_master_chk #(.N_SEL(N_SEL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .sdo       (sdo),
    .cs_out    (cs_out),
    .lvl_vec   (lvl_vec),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .xfer_busy (xfer_busy),
    .busy      (busy),
    .clk_en    (clk_en_q),
    .rdy       (rdy_q),
    .rx_done   (rx_done)
);

// File: tb/mw_master_bench.sv
module mw_master_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        sclk, sdo;
    logic        sdi = 1'b0;
    logic [3:0]  cs_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench-side slave state
    int          k_smp = 0, c_cap = 0, wr_b = 0, rd_b = 0;
    logic [15:0] pat = 16'h0, cap = 16'h0;
    logic        rxf = 1'b0, txf = 1'b0;
    logic        prev_sclk = 1'b0, prev_sdo = 1'b0, pre_rise_sdo = 1'b0;
    int          rises = 0, last_rise = 0, gap = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    mw_master u_mw_master (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo),
        .sdi(sdi), .cs_out(cs_out)
    );

    always @(negedge clk) begin
        if (sclk !== prev_sclk) begin
            if (sclk) begin
                if (rises == 0) pre_rise_sdo = prev_sdo;
                if (rises > 0) gap = cyc - last_rise;
                last_rise = cyc;
                rises++;
            end
            if ((sclk == 1'b1) == (rxf == 1'b0)) k_smp++;
            if ((sclk == 1'b1) == (txf == 1'b1) && c_cap < wr_b) begin
                cap = {cap[14:0], prev_sdo};
                c_cap++;
            end
        end
        prev_sclk = sclk;
        prev_sdo  = sdo;
        if (k_smp >= wr_b && k_smp - wr_b < rd_b)
            sdi = pat[rd_b - 1 - (k_smp - wr_b)];
        else
            sdi = 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] st;
        int n = 0;
        do begin
            bus_read(4'h2, st);
            n++;
        end while (st[14] && n < 6000);
        chk({req, " busy clears"}, st[14], 1'b0);
    endtask

    function automatic int clampi(input int v);
        return (v > 16) ? 16 : v;
    endfunction

    task automatic set_sel(input int idx, input logic [5:0] field);
        bus_write((idx < 2) ? 4'h4 : 4'h6, (idx % 2) ? {4'h0, field, 6'h0} : {10'h0, field});
    endtask

    task automatic start_xfer(input int idx, input int wr_raw, input int rd_raw,
                              input logic [15:0] txd, input logic [15:0] pt,
                              input logic rf, input logic tf, input logic [1:0] dv);
        set_sel(idx, {1'b0, dv, 1'b0, tf, rf});
        bus_write(4'h0, txd);
        wr_b = clampi(wr_raw); rd_b = clampi(rd_raw);
        pat = pt; rxf = rf; txf = tf;
        k_smp = 0; c_cap = 0; cap = 16'h0; rises = 0; gap = 0;
        bus_write(4'h2, 16'h2000 | 16'(idx << 10) | 16'((wr_raw & 31) << 5) | 16'(rd_raw & 31));
    endtask

    task automatic finish_xfer(input string req, input logic [15:0] txd, input logic [15:0] pt);
        logic [15:0] st, dv;
        logic [31:0] mask, exp_tx;
        wait_idle(req);
        mask   = (rd_b == 16) ? 32'hFFFF : ((32'h1 << rd_b) - 1);
        exp_tx = (wr_b == 0) ? 32'h0 : (32'(txd) >> (16 - wr_b));
        chk({req, " tx bit count"}, c_cap, wr_b);
        chk({req, " tx bits MSB first"}, 32'(cap), exp_tx);
        bus_read(4'h2, st);
        chk({req, " receive-ready"}, st[15], (rd_b > 0));
        bus_read(4'h0, dv);
        chk({req, " data register"}, dv, (rd_b > 0) ? (32'(pt) & mask) : 32'(txd));
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 cs_out", cs_out, 4'hF);
        chk("R1 sclk", sclk, 1'b0);
        chk("R1 sdo", sdo, 1'b0);
        for (int a = 0; a < 10; a += 2) begin
            bus_read(4'(a), v);
            chk("R1 register zero", v, 16'h0);
        end
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bus_write(4'h4, 16'hFABC);
        bus_read(4'h4, v);
        chk("R2 select 0/1 readback", v, 16'h0ABC);
        bus_write(4'h6, 16'h1234);
        bus_read(4'h6, v);
        chk("R2 select 2/3 readback", v, 16'h0234);
        bus_write(4'h8, 16'hFFFF);
        bus_read(4'h8, v);
        chk("R2 clock readback", v, 16'h0007);
        bus_write(4'h4, 16'h0);
        bus_write(4'h6, 16'h0);
        bus_write(4'h8, 16'h0001);
    endtask

    task automatic t_select();
        logic [15:0] v;
        bus_write(4'h4, 16'h0100);          // select 1 active-high (bit 8 = level of select 1)
        chk("R4 inactive levels", cs_out, 4'b1101);
        bus_write(4'h2, 16'h1800);          // assert select 2
        bus_addr = 4'h2;
        #1 chk("R3 busy during select command", bus_rdata[14], 1'b1);
        @(negedge clk);
        #1 chk("R3 busy clears after select command", bus_rdata[14], 1'b0);
        chk("R3 select 2 asserted low", cs_out, 4'b1001);
        bus_write(4'h2, 16'h1400);          // assert select 1
        chk("R4 select 1 drives high, select 2 released", cs_out, 4'b1111);
        bus_write(4'h2, 16'h0000);          // release
        chk("R3 release all", cs_out, 4'b1101);
        bus_write(4'h4, 16'h0);
        bus_read(4'h2, v);
        chk("R3 control fields read back", v, 16'h0000);
    endtask

    task automatic t_zero_counts();
        logic [15:0] v;
        bus_write(4'h2, 16'h2000);
        bus_read(4'h2, v);
        chk("R8 zero counts start nothing", v[14], 1'b0);
        chk("R8 no serial clock", sclk, 1'b0);
    endtask

    task automatic t_xfer(input string req, input int idx, input int wr_raw, input int rd_raw,
                          input logic [15:0] txd, input logic [15:0] pt,
                          input logic rf, input logic tf);
        start_xfer(idx, wr_raw, rd_raw, txd, pt, rf, tf, 2'd0);
        finish_xfer(req, txd, pt);
        if (wr_b > 0)
            chk({req, " R5 sdo before first rise"}, pre_rise_sdo, tf ? txd[15] : 1'b0);
    endtask

    task automatic t_ready_clear();
        logic [15:0] v;
        start_xfer(0, 0, 6, 16'h0, 16'h002D, 1'b0, 1'b0, 2'd0);
        wait_idle("R9");
        bus_read(4'h2, v);
        chk("R9 ready set before read", v[15], 1'b1);
        bus_read(4'h0, v);
        chk("R9 data", v, 16'h002D);
        bus_read(4'h2, v);
        chk("R9 ready cleared by data read", v[15], 1'b0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        bus_write(4'h8, 16'h0007);           // base /10
        start_xfer(0, 4, 4, 16'hA000, 16'h0009, 1'b0, 1'b0, 2'd2);
        bus_write(4'h0, 16'h1234);
        bus_write(4'h2, 16'h2000 | 16'(16 << 5));
        bus_write(4'h2, 16'h1000);
        chk("R10 select command ignored while busy", cs_out, 4'hF);
        wait_idle("R10");
        chk("R10 tx count from first command", c_cap, 4);
        chk("R10 tx bits", cap, 16'h000A);
        bus_read(4'h0, v);
        chk("R10 data register holds receive result", v, 16'h0009);
        bus_read(4'h2, v);
        chk("R10 control fields from first command", v[9:0], 10'((4 << 5) | 4));
        bus_write(4'h8, 16'h0001);
    endtask

    task automatic t_period(input logic [1:0] bc, input logic [1:0] sc, input int exp);
        bus_write(4'h8, {13'h0, bc, 1'b1});
        start_xfer(3, 4, 0, 16'h5000, 16'h0, 1'b0, 1'b1, sc);
        finish_xfer("R11", 16'h5000, 16'h0);
        chk($sformatf("R11 sclk period base=%0d div=%0d", bc, sc), gap, exp);
    endtask

    task automatic t_enable();
        logic [15:0] v;
        bus_write(4'h8, 16'h0000);
        start_xfer(1, 3, 3, 16'hC000, 16'h0005, 1'b1, 1'b0, 2'd0);
        repeat (200) @(negedge clk);
        chk("R12 no serial clock while disabled", rises, 0);
        bus_read(4'h2, v);
        chk("R12 command waits while disabled", v[14], 1'b1);
        bus_write(4'h8, 16'h0001);
        finish_xfer("R12 resumes", 16'hC000, 16'h0005);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_select();
        t_zero_counts();
        t_xfer("R5 tx-only 8 bits, rising launch (R7)", 0, 8, 0, 16'hB700, 16'h0, 1'b0, 1'b0);
        t_xfer("R6 rx-only 5 bits, falling sample (R7)", 0, 0, 5, 16'h0, 16'hFFF3, 1'b1, 1'b0);
        t_xfer("R7 12 out then 16 in, idx 3", 3, 12, 16, 16'h9AC0, 16'hC3A5, 1'b0, 1'b1);
        t_xfer("R6 16 out then 1 in, idx 2", 2, 16, 1, 16'h8001, 16'hFFFF, 1'b1, 1'b1);
        t_xfer("R8 count 20 acts as 16", 1, 20, 0, 16'h5A3C, 16'h0, 1'b0, 1'b1);
        t_ready_clear();
        t_busy_ignore();
        t_period(2'd2, 2'd0, 14);
        t_period(2'd3, 2'd2, 80);
        t_period(2'd0, 2'd1, 8);
        t_period(2'd1, 2'd3, 32);
        bus_write(4'h8, 16'h0001);
        t_enable();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule